// File: doc/BRIEF.md
# Half-Select Exact Leading-One Detector

This block finds the position of the most significant set bit in an unsigned word. It is intended as the front end of a logarithmic multiplier. A single OR over the upper half of the word decides which half to pass on. The upper half is passed when it holds any set bit; otherwise the lower half is passed. Only that half reaches one half-width priority encoder, so a single narrow detector switches for each input, which keeps the energy per operation low. The result is exact.

The encoder index and the half-select bit are merged into the full bit position. When the half width is a power of two, the half-select bit becomes the top bit of the position. For other widths a small adder adds the half offset instead. The block also returns the bits below the leading one, left-aligned and padded with zeros at the bottom. This is the fractional part of the binary logarithm. An all-zero input raises a flag.

The block is purely combinational and has no clock or reset. The width defaults to 32. The width must be even and at least 4; any other value stops elaboration.

Top module: `hs_lead_one_det`

## Requirements
- R1: For any nonzero input, `lead_pos` equals the index of the most significant set bit of `word_in`, with no approximation.
- R2: When the upper half `word_in[WIDTH-1:WIDTH/2]` holds a set bit, `lead_pos` is at least WIDTH/2, and changing only the lower half leaves `lead_pos` unchanged.
- R3: When the upper half is all zero and the lower half is not, `lead_pos` is below WIDTH/2 and is the index of the top set bit of the lower half.
- R4: For an all-zero input, `is_zero` is 1, `lead_pos` is 0 and `mant_out` is 0. For any nonzero input, `is_zero` is 0.
- R5: `mant_out` (WIDTH-1 bits) holds the input bits below the leading one. Bit `lead_pos-1` of the input lands at `mant_out[WIDTH-2]`, and the bits below them are filled with zeros.
- R6: The outputs depend only on the present input and settle within the same time step in which `word_in` changes, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word_in | input | WIDTH | Unsigned operand |
| lead_pos | output | $clog2(WIDTH) | Index of the most significant set bit |
| is_zero | output | 1 | High when the operand has no set bit |
| mant_out | output | WIDTH-1 | Bits below the leading one, left-aligned |

## Verification
The hardest case to reach from the ports is an upper half that holds exactly one set bit while the lower half is dense. In that case the half select must ignore many lower-half ones, and the encoder sees a single sparse bit. To reach it, the stimulus fixes one upper-half bit and sweeps the lower half through dense and random patterns, checking that `lead_pos` stays put. Walking a single one across every position covers the half boundary (bits WIDTH/2-1 and WIDTH/2) and the edges at bit 0 and bit WIDTH-1.

// File: rtl/lod_pkg.sv
package lod_pkg;
  // Width of an index into a vector of n bits (at least one bit).
  function automatic int idx_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // True when n is a power of two.
  function automatic bit is_pow2(input int n);
    return (n > 0) && ((n & (n - 1)) == 0);
  endfunction
endpackage

// File: rtl/lod_half_mux.sv
module lod_half_mux #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]   word_in,
  output logic [WIDTH/2-1:0] half_fwd,
  output logic               upper_hit
);
  localparam int HALF = WIDTH / 2;

  logic [HALF-1:0] upper_part;
  logic [HALF-1:0] lower_part;

  always_comb begin
    upper_part = word_in[WIDTH-1:HALF];
    lower_part = word_in[HALF-1:0];
    upper_hit  = |upper_part;
    half_fwd   = upper_hit ? upper_part : lower_part;
  end

  // R2: a nonzero upper half is never passed over for the lower one
  always_comb begin
    assert_upper_taken_R2: assert (!upper_hit || (half_fwd != '0))
      else $error("upper half selected but forwarded half is zero");
  end
endmodule

// File: rtl/lod_prio_enc.sv
module lod_prio_enc #(
  parameter int N = 16
) (
  input  logic [N-1:0]                  vec_in,
  output logic [lod_pkg::idx_w(N)-1:0]  top_idx,
  output logic                          any_set
);
  localparam int IW = lod_pkg::idx_w(N);

  always_comb begin
    top_idx = '0;
    any_set = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (vec_in[i]) begin
        top_idx = IW'(i);
        any_set = 1'b1;
      end
    end
  end

  // R1: the reported bit is set and nothing above it is set
  always_comb begin
    assert_idx_exact_R1: assert (!any_set ||
        ((vec_in >> top_idx) == N'(1)))
      else $error("half encoder index is not the top set bit");
  end
endmodule

// File: rtl/lod_norm.sv
module lod_norm #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]             word_in,
  input  logic [$clog2(WIDTH)-1:0]     lead_pos,
  input  logic                         is_zero,
  output logic [WIDTH-2:0]             mant_out
);
  localparam int PW = $clog2(WIDTH);

  logic [PW-1:0]    shamt;
  logic [WIDTH-1:0] shifted;

  always_comb begin
    shamt    = PW'(WIDTH - 1) - lead_pos;
    shifted  = word_in << shamt;
    mant_out = shifted[WIDTH-2:0];
  end

  // R5: restoring the hidden one and shifting back recovers the operand
  always_comb begin
    assert_mant_roundtrip_R5: assert (is_zero ||
        (({1'b1, mant_out} >> shamt) == word_in))
      else $error("fraction does not reconstruct the operand");
    assert_mant_zero_R4: assert (!is_zero || (mant_out == '0))
      else $error("fraction nonzero for a zero operand");
  end
endmodule

// File: rtl/hs_lead_one_det.sv
module hs_lead_one_det #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]         word_in,
  output logic [$clog2(WIDTH)-1:0] lead_pos,
  output logic                     is_zero,
  output logic [WIDTH-2:0]         mant_out
);
  localparam int HALF = WIDTH / 2;
  localparam int PW   = $clog2(WIDTH);
  localparam int HW   = lod_pkg::idx_w(HALF);

  generate
    if ((WIDTH % 2 != 0) || (WIDTH < 4)) begin : g_bad_width
      $fatal(1, "hs_lead_one_det: WIDTH must be even and at least 4");
    end
  endgenerate

  logic [HALF-1:0] half_fwd;
  logic            upper_hit;
  logic [HW-1:0]   half_idx;
  logic            half_any;

  lod_half_mux #(.WIDTH(WIDTH)) u_sel (
    .word_in   (word_in),
    .half_fwd  (half_fwd),
    .upper_hit (upper_hit)
  );

  lod_prio_enc #(.N(HALF)) u_enc (
    .vec_in  (half_fwd),
    .top_idx (half_idx),
    .any_set (half_any)
  );

  generate
    if (lod_pkg::is_pow2(HALF)) begin : g_concat
      always_comb lead_pos = {upper_hit, half_idx};
    end else begin : g_offset
      always_comb lead_pos = upper_hit ? (PW'(HALF) + PW'(half_idx))
                                       : PW'(half_idx);
    end
  endgenerate

  always_comb is_zero = ~half_any;

  lod_norm #(.WIDTH(WIDTH)) u_norm (
    .word_in  (word_in),
    .lead_pos (lead_pos),
    .is_zero  (is_zero),
    .mant_out (mant_out)
  );

  always_comb begin
    assert_pos_exact_R1: assert (is_zero ||
        ((word_in >> lead_pos) == WIDTH'(1)))
      else $error("position is not the top set bit");
    assert_upper_range_R2: assert (!(|word_in[WIDTH-1:HALF]) ||
        (int'(lead_pos) >= HALF))
      else $error("upper half set but position below half");
    assert_lower_range_R3: assert ((|word_in[WIDTH-1:HALF]) ||
        (int'(lead_pos) < HALF))
      else $error("upper half clear but position in upper half");
    assert_zero_flag_R4: assert ((is_zero == (word_in == '0)) &&
        (!is_zero || (lead_pos == '0)))
      else $error("zero flag or zero position wrong");
  end
endmodule

// File: tb/test_hs_lead_one_det.sv
module test_hs_lead_one_det;
  localparam int WIDTH = 32;
  localparam int HALF  = WIDTH / 2;
  localparam int PW    = $clog2(WIDTH);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [WIDTH-1:0] word_in;
  logic [PW-1:0]    lead_pos;
  logic             is_zero;
  logic [WIDTH-2:0] mant_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  hs_lead_one_det #(.WIDTH(WIDTH)) i_hs_lead_one_det (
    .word_in  (word_in),
    .lead_pos (lead_pos),
    .is_zero  (is_zero),
    .mant_out (mant_out)
  );

  function automatic int ref_pos(input logic [WIDTH-1:0] w);
    int p = 0;
    for (int i = 0; i < WIDTH; i++) if (w[i]) p = i;
    return p;
  endfunction

  function automatic logic [WIDTH-2:0] ref_mant(input logic [WIDTH-1:0] w);
    logic [WIDTH-2:0] m = '0;
    int p = ref_pos(w);
    for (int j = 0; j < p; j++) m[WIDTH-2-(p-1-j)] = w[j];
    return m;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (word 0x%0h)",
               req, act, exp, word_in);
    end
  endtask

  // Drive a word, let it settle away from the clock edge, compare all outputs.
  task automatic apply_and_check(input logic [WIDTH-1:0] w, input string tag);
    word_in = w;
    #2;
    if (w == '0) begin
      check(is_zero == 1'b1, {"R4 zero flag ", tag}, WIDTH'(is_zero), 1);
      check(lead_pos == '0, {"R4 zero pos ", tag}, WIDTH'(lead_pos), 0);
      check(mant_out == '0, {"R4 zero mant ", tag}, WIDTH'(mant_out), 0);
    end else begin
      check(is_zero == 1'b0, {"R4 nonzero flag ", tag}, WIDTH'(is_zero), 0);
      check(int'(lead_pos) == ref_pos(w), {"R1 position ", tag},
            WIDTH'(lead_pos), WIDTH'(ref_pos(w)));
      check(mant_out == ref_mant(w), {"R5 fraction ", tag},
            WIDTH'(mant_out), WIDTH'(ref_mant(w)));
    end
  endtask

  task automatic t_zero_word;
    apply_and_check('0, "all-zero");
  endtask

  task automatic t_single_ones;
    for (int k = 0; k < WIDTH; k++) apply_and_check(WIDTH'(1) << k, "walking one");
  endtask

  task automatic t_random_words;
    for (int n = 0; n < 400; n++) begin
      logic [WIDTH-1:0] w = WIDTH'($urandom) >> ($urandom % WIDTH);
      apply_and_check(w, "random");
    end
    apply_and_check('1, "all ones");
  endtask

  // R2: one upper bit fixed, lower half swept dense and random
  task automatic t_upper_dominates;
    for (int u = HALF; u < WIDTH; u++) begin
      for (int n = 0; n < 6; n++) begin
        logic [WIDTH-1:0] w = WIDTH'(1) << u;
        w[HALF-1:0] = (n == 0) ? '1 : HALF'($urandom);
        word_in = w;
        #2;
        check(int'(lead_pos) == u, "R2 lower half ignored", WIDTH'(lead_pos), WIDTH'(u));
      end
    end
  endtask

  // R3: upper half clear, lower half drives the result
  task automatic t_lower_only;
    for (int n = 0; n < 60; n++) begin
      logic [WIDTH-1:0] w = '0;
      w[HALF-1:0] = HALF'($urandom) | HALF'(1);
      w[HALF-1:0] = w[HALF-1:0] >> ($urandom % HALF);
      word_in = w;
      #2;
      check((int'(lead_pos) < HALF) && (int'(lead_pos) == ref_pos(w)),
            "R3 lower half position", WIDTH'(lead_pos), WIDTH'(ref_pos(w)));
    end
  endtask

  // R6: outputs follow the input between clock edges, no edge involved
  task automatic t_combinational;
    @(posedge clk);
    #1 word_in = WIDTH'(1) << (HALF + 3);
    #1 check(int'(lead_pos) == HALF + 3, "R6 no clock needed",
             WIDTH'(lead_pos), WIDTH'(HALF + 3));
    word_in = WIDTH'(5);
    #1 check(int'(lead_pos) == 2, "R6 follows new input", WIDTH'(lead_pos), 2);
  endtask

  initial begin
    word_in = '0;
    #3;
    t_zero_word();
    t_single_ones();
    t_upper_dominates();
    t_lower_only();
    t_random_words();
    t_combinational();
    t_zero_word();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule